// File: doc/BRIEF.md
# One-Shot Prescaled Countdown Timer

This block is the countdown timer of a per-core interrupt controller. Software programs a divider setting and then a start value. The timer counts that many prescaled periods and then raises a single-cycle expiry strobe. A base-tick input marks the edges of the slow base clock. Each prescaled period is a power-of-two number of those base ticks. While the countdown runs, software can read how many prescaled periods are still left.

Access goes through a simple register port with three locations. The start-value register is at offset 0x380, the remaining-count register at 0x390 and the divider setting at 0x3E0. A read returns its data one cycle later with a valid flag. Writing the start value always restarts the countdown. The timer is one-shot: after it expires it stays idle until the next start write.

Top module: `lapic_timer`

## Requirements
- R1: After reset, expiry is low, read-valid is low, and reads of all three registers return 0.
- R2: The divider code is the 3-bit value {setting[3], setting[1:0]}. The divide ratio is 2^((code+1) mod 8), so code 7 divides by 1 and code 0 divides by 2.
- R3: A write to the divider setting keeps only bits 3, 1 and 0. All other bits read back as 0.
- R4: A nonzero start value N written in a cycle where base_tick is high makes expiry fire on the (N × ratio)-th base tick after that write.
- R5: If base_tick is low in the write cycle, one extra base tick is added, so expiry fires on the (N × ratio + 1)-th base tick.
- R6: Expiry is high for exactly one clock cycle per countdown, and the timer is idle afterwards.
- R7: While the timer runs, the remaining-count register reads as the number of base ticks left divided by the ratio, rounded up. When the timer is idle it reads 0.
- R8: Writes to the remaining-count register have no effect.
- R9: Writing a start value of 0 leaves the timer idle and produces no expiry.
- R10: A start write during a running countdown discards the old countdown and starts the new one.
- R11: Read data and read-valid appear in the cycle after a read request. Unmapped offsets read 0.
- R12: The start-value register reads back the last value written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| base_tick | input | 1 | One-cycle strobe marking a base-clock edge |
| wr_en | input | 1 | Register write request |
| rd_en | input | 1 | Register read request |
| addr | input | 12 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered |
| rvalid | output | 1 | Read data valid, one cycle after rd_en |
| expire | output | 1 | Single-cycle countdown expiry strobe |

## Verification
The bench sweeps all eight divider codes against several start values. It places each start write both on and off a base tick, and counts base ticks up to the expiry strobe. A design that decoded the split divider field in the wrong order, or failed to wrap code 7 to divide-by-1, would expire at a multiple of the right time. A design that ignored the write-phase rule would be one tick early or late.

Mid-countdown reads check the rounded-up remaining count. Truncating instead of rounding up would read one less on partial periods. The bench also covers zero start values, restarts and writes to the read-only count. A design that counted from zero, pulsed twice, or let those writes through would show a spurious strobe or a wrong read-back.

// File: rtl/lapic_timer_pkg.sv
package lapic_timer_pkg;
  localparam int CFG_W = 4;
  localparam logic [CFG_W-1:0] CFG_KEEP = 4'b1011;

  // split 3-bit code, shift wraps modulo 8
  function automatic logic [2:0] code_to_shift(input logic [CFG_W-1:0] cfg);
    logic [2:0] code;
    code = {cfg[3], cfg[1:0]};
    return code + 3'd1;
  endfunction
endpackage

// File: rtl/lapic_timer_divcfg.sv
module lapic_timer_divcfg
  import lapic_timer_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [CFG_W-1:0] wval,
  output logic [CFG_W-1:0] cfg,
  output logic [2:0]       shift
);
  logic [CFG_W-1:0] cfg_q;

  always_ff @(posedge clk) begin
    if (rst)     cfg_q <= '0;
    else if (wr) cfg_q <= wval & CFG_KEEP;
  end

  assign cfg   = cfg_q;
  assign shift = code_to_shift(cfg_q);
endmodule

// File: rtl/lapic_timer_core.sv
module lapic_timer_core #(
  parameter int CNT_W = 32,
  localparam int REM_W = CNT_W + 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [2:0]       shift,
  output logic [REM_W-1:0] remain,
  output logic             expire
);
  logic [REM_W-1:0] rem_q;
  logic             exp_q;
  logic [REM_W-1:0] span;

  assign span = REM_W'(load_val) << shift;

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q <= '0;
      exp_q <= 1'b0;
    end else if (load) begin
      rem_q <= (load_val == '0) ? '0 : span + REM_W'(!tick);
      exp_q <= 1'b0;
    end else begin
      exp_q <= tick && (rem_q == REM_W'(1));
      if (tick && rem_q != '0) rem_q <= rem_q - REM_W'(1);
    end
  end

  assign remain = rem_q;
  assign expire = exp_q;

  // R6
  pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
    exp_q |=> !exp_q);
  // R6
  pulse_from_last_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(exp_q) |-> $past(rem_q) == REM_W'(1));
  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (rem_q == '0 && !load) |=> !exp_q);
  // R10
  no_grow_chk: assert property (@(posedge clk) disable iff (rst)
    !load |=> rem_q <= $past(rem_q));
endmodule

// File: rtl/lapic_timer_readout.sv
module lapic_timer_readout #(
  parameter int CNT_W = 32,
  localparam int REM_W = CNT_W + 7
) (
  input  logic [REM_W-1:0] remain,
  input  logic [2:0]       shift,
  output logic [CNT_W-1:0] periods
);
  logic [REM_W:0] bias;
  logic [REM_W:0] sum;

  always_comb begin
    bias    = ((REM_W+1)'(1) << shift) - (REM_W+1)'(1);
    sum     = ((REM_W+1)'(remain) + bias) >> shift;
    periods = sum[CNT_W-1:0];
  end
endmodule

// File: rtl/lapic_timer.sv
module lapic_timer
  import lapic_timer_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] OFS_START = 12'h380,
  parameter logic [ADDR_W-1:0] OFS_LEFT  = 12'h390,
  parameter logic [ADDR_W-1:0] OFS_DIV   = 12'h3E0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              base_tick,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid,
  output logic              expire
);
  localparam int REM_W = DATA_W + 7;

  logic              wr_start, wr_div;
  logic [CFG_W-1:0]  cfg;
  logic [2:0]        shift;
  logic [REM_W-1:0]  remain;
  logic [DATA_W-1:0] periods;
  logic [DATA_W-1:0] start_q;
  logic [DATA_W-1:0] rd_mux;
  logic [DATA_W-1:0] rdata_q;
  logic              rvalid_q;

  assign wr_start = wr_en && addr == OFS_START;
  assign wr_div   = wr_en && addr == OFS_DIV;

  lapic_timer_divcfg i_divcfg (
    .clk(clk), .rst(rst), .wr(wr_div), .wval(wdata[CFG_W-1:0]),
    .cfg(cfg), .shift(shift)
  );

  lapic_timer_core #(.CNT_W(DATA_W)) i_core (
    .clk(clk), .rst(rst), .tick(base_tick), .load(wr_start),
    .load_val(wdata), .shift(shift), .remain(remain), .expire(expire)
  );

  lapic_timer_readout #(.CNT_W(DATA_W)) i_readout (
    .remain(remain), .shift(shift), .periods(periods)
  );

  always_ff @(posedge clk) begin
    if (rst)           start_q <= '0;
    else if (wr_start) start_q <= wdata;
  end

  always_comb begin
    rd_mux = '0;
    if (addr == OFS_START)     rd_mux = start_q;
    else if (addr == OFS_LEFT) rd_mux = periods;
    else if (addr == OFS_DIV)  rd_mux = DATA_W'(cfg);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd_en;
      if (rd_en) rdata_q <= rd_mux;
    end
  end

  assign rdata  = rdata_q;
  assign rvalid = rvalid_q;

  // R11
  read_valid_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rvalid);
  // R11
  read_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rvalid);
endmodule

// File: tb/test_lapic_timer.sv
`timescale 1ns/1ps
module test_lapic_timer;
  logic        clk = 1'b0, rst = 1'b1, base_tick = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rvalid, expire;

  int checks = 0, errors = 0;
  int ticks_seen = 0;
  int base = 0;
  int exp_cnt = 0, exp_elapsed = -1;

  localparam logic [11:0] A_START = 12'h380, A_LEFT = 12'h390, A_DIV = 12'h3E0;

  lapic_timer i_lapic_timer (
    .clk(clk), .rst(rst), .base_tick(base_tick), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .rvalid(rvalid), .expire(expire)
  );

  always #4 clk = ~clk;

  // base tick every second clock; count ticks sampled at the previous edge
  initial forever begin
    @(negedge clk);
    if (base_tick) ticks_seen++;
    base_tick = ~base_tick;
  end

  initial begin
    #(8ns * 190000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cycle();
    @(negedge clk); #1;
    if (expire) begin
      exp_cnt++;
      exp_elapsed = ticks_seen - base;
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    cycle();
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d, output logic v);
    rd_en = 1'b1; addr = a;
    cycle();
    rd_en = 1'b0;
    d = rdata; v = rvalid;
  endtask

  function automatic longint ceil_div(input longint x, input int sh);
    return (x + (longint'(1) << sh) - 1) >> sh;
  endfunction

  // start write with chosen tick phase; returns total ticks expected
  task automatic start(input int n, input int sh, input bit on_edge, output longint tot);
    while (base_tick != on_edge) cycle();
    base = ticks_seen + (base_tick ? 1 : 0);
    tot = (n == 0) ? 0 : (longint'(n) << sh) + (on_edge ? 0 : 1);
    exp_cnt = 0; exp_elapsed = -1;
    wr(A_START, n);
  endtask

  initial begin
    logic [31:0] d;
    logic v;
    longint tot;
    repeat (3) cycle();
    rst = 1'b0;
    cycle();
    // R1 reset state
    chk("R1 expire", expire, 0);
    chk("R1 rvalid", rvalid, 0);
    rd(A_START, d, v); chk("R1 start", d, 0);
    chk("R11 rvalid", v, 1);
    rd(A_LEFT, d, v);  chk("R1 left", d, 0);
    rd(A_DIV, d, v);   chk("R1 div", d, 0);
    // R3 mask
    wr(A_DIV, 32'hFFFF_FFFF);
    rd(A_DIV, d, v); chk("R3 mask all", d, 32'hB);
    wr(A_DIV, 32'h0000_0F74);
    rd(A_DIV, d, v); chk("R3 mask sparse", d, 32'h0);
    // R11 unmapped
    rd(12'h3A0, d, v); chk("R11 unmapped", d, 0);
    cycle(); chk("R11 rvalid drop", rvalid, 0);
    // R12 readback
    wr(A_START, 32'hDEAD_0000); wr(A_START, 0);
    wr(A_START, 32'h1234_5678); wr(A_START, 0);
    rd(A_START, d, v); chk("R12 readback zero", d, 0);
    // R8 write to count ignored while idle
    wr(A_LEFT, 32'd77);
    rd(A_LEFT, d, v); chk("R8 idle", d, 0);

    // R2 R4 R5 R6 R7 sweep over codes, values and phases
    for (int code = 0; code < 8; code++) begin
      for (int n = 1; n <= 3; n++) begin
        for (int ph = 0; ph < 2; ph++) begin
          int sh;
          int guard;
          longint left;
          sh = (code + 1) % 8;
          wr(A_DIV, {28'd0, code[2], 1'b0, code[1:0]});
          start(n, sh, ph[0], tot);
          repeat (int'(tot)) cycle();
          left = tot - (ticks_seen - base);
          if (left < 0) left = 0;
          rd(A_LEFT, d, v);
          chk($sformatf("R7 left code=%0d n=%0d", code, n), d, ceil_div(left, sh));
          guard = 0;
          while (exp_cnt == 0 && guard < 2000) begin cycle(); guard++; end
          repeat (4) cycle();
          chk($sformatf("R2 R4 R5 ticks code=%0d n=%0d edge=%0d", code, n, ph),
              exp_elapsed, tot);
          chk($sformatf("R6 pulses code=%0d n=%0d", code, n), exp_cnt, 1);
          rd(A_LEFT, d, v);
          chk("R6 R7 idle after", d, 0);
        end
      end
    end

    // R8 write to count while running
    wr(A_DIV, 32'h3);               // code 3, ratio 16
    start(4, 4, 1'b1, tot);         // 64 ticks
    wr(A_LEFT, 32'd1);
    left_check: begin
      longint left;
      left = tot - (ticks_seen - base);
      rd(A_LEFT, d, v);
      chk("R8 running", d, ceil_div(left, 4));
    end
    // R10 restart mid-run with a shorter count
    repeat (20) cycle();
    start(2, 4, 1'b0, tot);         // 33 ticks
    begin
      int guard = 0;
      while (exp_cnt == 0 && guard < 2000) begin cycle(); guard++; end
    end
    repeat (4) cycle();
    chk("R10 restart ticks", exp_elapsed, tot);
    chk("R10 one pulse", exp_cnt, 1);

    // R9 zero start value
    wr(A_DIV, 32'h8);               // code 4, ratio 32
    start(3, 5, 1'b1, tot);
    repeat (10) cycle();
    start(0, 5, 1'b0, tot);
    repeat (300) cycle();
    chk("R9 no pulse", exp_cnt, 0);
    rd(A_LEFT, d, v); chk("R9 idle", d, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule